// File: doc/BRIEF.md
# ECC RAM with subword read-modify-write

This block wraps a single-port on-chip memory. Every stored entry is one data word together with its SECDED check bits. An extended Hamming code produces the check bits. It is a Hamming code over the whole data word, widened by one overall parity bit. For the default 64-bit word there are 8 check bits, so each stored entry is 72 bits.

Requests use a valid/ready handshake and carry a write flag, a word address, per-byte enables and write data.

- **Full-word write.** A write with every byte enable set is encoded and stored in the cycle it is accepted. It gives no response.
- **Read.** A read returns corrected data one cycle after acceptance. It also returns a single-error flag and a double-error flag.
- **Partial write.** A write with only some byte enables set is never stored directly. The block first reads the old entry and checks its syndrome. It then corrects a single-bit error if one is present. It merges the enabled bytes into the corrected word and encodes the merged word again. Finally it writes the result back through the same port, one cycle after the read.
- **Partial write on a damaged word.** If the old word holds an uncorrectable error, the write-back is dropped and memory stays as it was.

While such a sequence runs, ready is low, so no other request can slip in between the read and the write-back.

Top module: `ecc_word_ram`

## Requirements
- R1: Each entry is stored as {check, data}, with the data in bits DATA_W-1:0. For DATA_W=64 the check field is 8 bits. The bit layout is as follows.
  - Codeword positions 1..71 are numbered so that the powers of two (1, 2, 4, ..., 64) hold Hamming bits 0..6.
  - The data bits fill the other positions in ascending order, so data bit 0 sits at position 3.
  - Hamming bit i is the XOR of the data bits whose position has bit i set.
  - Check bit 7 is the XOR of all data bits and Hamming bits.
  - An entry stored in this form reads back unchanged with both flags low.
- R2: A full-word write (all byte enables set) followed by a read of the same address returns the written data with rsp_sec=0 and rsp_ded=0.
- R3: A read accepted at a clock edge gives rsp_valid high for exactly the next cycle, with the data and flags, and req_ready low in that cycle.
- R4: A full-word write is accepted in one cycle. req_ready stays high, and rsp_valid stays low in the following cycle. After reset, req_ready is high and rsp_valid is low.
- R5: A partial write replaces only the bytes whose enables are set. Enable bit b controls data bits 8b+7:8b. All other bytes keep their old values.
- R6: A partial write gives rsp_valid high for exactly one cycle after acceptance, with req_ready low in that cycle. It reports the syndrome flags of the old word.
- R7: A single flipped data bit is corrected on read, with rsp_sec=1 and rsp_ded=0.
- R8: Two flipped data bits in one entry give rsp_ded=1 and rsp_sec=0 on read, and rsp_rdata carries the stored data bits unmodified.
- R9: A partial write to an entry with a single-bit error corrects the old word before the merge and reports rsp_sec=1. A later read of that entry returns the merged data with both flags low.
- R10: A partial write to an entry with a double-bit error reports rsp_ded=1 and writes nothing. A later read still reports rsp_ded=1 and returns the old stored data bits.
- R11: A single flipped check bit, including the overall parity bit, gives rsp_sec=1 and leaves the returned data intact.
- R12: rsp_sec and rsp_ded are never high together in a response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request (low during a read or partial write) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_be | input | DATA_W/8 | Byte enables for writes |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response for a read or partial write |
| rsp_rdata | output | DATA_W | Corrected data (old word for a partial write) |
| rsp_sec | output | 1 | Single-bit error found and corrected |
| rsp_ded | output | 1 | Uncorrectable error found |

## Verification
The bench uses the defaults DATA_W=64 and ADDR_W=4. This gives a 72-bit entry with 7 Hamming bits plus overall parity, and 16 words, so random traffic revisits every address often and builds up stacked partial merges. With 64-bit data, a flipped bit can be placed at the lowest and highest data positions, on a Hamming bit, and on the overall parity bit. Faults are planted by depositing codewords that the bench encodes itself. This puts the single-error and double-error paths of reads and of read-modify-write within reach.

// File: rtl/ecc_word_pkg.sv
package ecc_word_pkg;

  localparam int MAXW = 256;

  // number of Hamming bits p with 2^p >= dw + p + 1
  function automatic int hamming_bits(int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

  // codeword position (1-based) of data bit j, skipping powers of two
  function automatic int data_pos(int j);
    int cnt;
    cnt = 0;
    for (int q = 1; q < 4096; q++) begin
      if ((q & (q - 1)) != 0) begin
        if (cnt == j) return q;
        cnt++;
      end
    end
    return 0;
  endfunction

  // data bits covered by Hamming bit i
  function automatic logic [MAXW-1:0] check_mask(int i, int dw);
    logic [MAXW-1:0] m;
    m = '0;
    for (int j = 0; j < dw; j++)
      if (((data_pos(j) >> i) & 1) == 1) m[j] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/ecc_word_enc.sv
module ecc_word_enc
  import ecc_word_pkg::*;
#(
  parameter  int DATA_W = 64,
  localparam int HAM_W  = hamming_bits(DATA_W),
  localparam int CHK_W  = HAM_W + 1
) (
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);

  logic [HAM_W-1:0] ham;

  for (genvar i = 0; i < HAM_W; i++) begin : g_ham
    localparam logic [MAXW-1:0] COVER = check_mask(i, DATA_W);
    assign ham[i] = ^(data & COVER[DATA_W-1:0]);
  end

  assign chk = {^{data, ham}, ham};

endmodule

// File: rtl/ecc_word_dec.sv
module ecc_word_dec
  import ecc_word_pkg::*;
#(
  parameter  int DATA_W = 64,
  localparam int HAM_W  = hamming_bits(DATA_W),
  localparam int CHK_W  = HAM_W + 1
) (
  input  logic [DATA_W-1:0] data,
  input  logic [CHK_W-1:0]  chk,
  output logic [DATA_W-1:0] corr,
  output logic              sec,
  output logic              ded
);

  localparam int               CODE_N   = DATA_W + HAM_W;
  localparam logic [HAM_W-1:0] CODE_TOP = HAM_W'(CODE_N);

  logic [CHK_W-1:0] chk_re;
  logic [HAM_W-1:0] syn;
  logic             par_err;
  logic             in_range;

  ecc_word_enc #(.DATA_W(DATA_W)) u_reenc (
    .data (data),
    .chk  (chk_re)
  );

  assign syn      = chk[HAM_W-1:0] ^ chk_re[HAM_W-1:0];
  // total parity over data, Hamming bits and stored overall bit
  assign par_err  = chk[HAM_W] ^ chk_re[HAM_W] ^ (^syn);
  assign in_range = (syn <= CODE_TOP);

  for (genvar j = 0; j < DATA_W; j++) begin : g_fix
    localparam int POS = data_pos(j);
    assign corr[j] = data[j] ^ (par_err & (syn == HAM_W'(POS)));
  end

  assign sec = par_err & in_range;
  assign ded = (~par_err & (syn != '0)) | (par_err & ~in_range);

endmodule

// File: rtl/ecc_word_mem.sv
module ecc_word_mem #(
  parameter  int WORD_W = 72,
  parameter  int ADDR_W = 4,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
    if (rd_en) rdata <= mem[addr];
  end

endmodule

// File: rtl/ecc_word_ram.sv
module ecc_word_ram
  import ecc_word_pkg::*;
#(
  parameter  int DATA_W = 64,
  parameter  int ADDR_W = 4,
  localparam int BYTES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTES-1:0]  req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_sec,
  output logic              rsp_ded
);

  localparam int HAM_W  = hamming_bits(DATA_W);
  localparam int CHK_W  = HAM_W + 1;
  localparam int WORD_W = DATA_W + CHK_W;

  typedef enum logic {ST_IDLE, ST_BUSY} seq_state_e;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTES-1:0]  be_q;
  logic [DATA_W-1:0] wdata_q;
  logic              op_wr_q;

  logic              accept, full_wr, start_busy, busy;
  logic              ram_rd, ram_wr;
  logic [ADDR_W-1:0] ram_addr;
  logic [WORD_W-1:0] ram_wdata, ram_q;
  logic [DATA_W-1:0] enc_in, corr_data, merged;
  logic [CHK_W-1:0]  enc_chk;
  logic              dec_sec, dec_ded;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign busy       = (state_q == ST_BUSY);
  assign req_ready  = ~busy;
  assign accept     = req_valid & req_ready;
  assign full_wr    = accept & req_write & (&req_be);
  assign start_busy = accept & ~full_wr;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_busy) state_d = ST_BUSY;
      ST_BUSY: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      op_wr_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_busy) begin
        addr_q  <= req_addr;
        be_q    <= req_be;
        wdata_q <= req_wdata;
        op_wr_q <= req_write;
      end
    end
  end

  // old word after correction, merged with the enabled new bytes
  for (genvar b = 0; b < BYTES; b++) begin : g_merge
    assign merged[8*b +: 8] = be_q[b] ? wdata_q[8*b +: 8] : corr_data[8*b +: 8];
  end

  assign enc_in    = busy ? merged : req_wdata;
  assign ram_addr  = busy ? addr_q : req_addr;
  assign ram_rd    = start_busy;
  assign ram_wr    = full_wr | (busy & op_wr_q & ~dec_ded);
  assign ram_wdata = {enc_chk, enc_in};

  ecc_word_enc #(.DATA_W(DATA_W)) u_enc (
    .data (enc_in),
    .chk  (enc_chk)
  );

  ecc_word_mem #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .rd_en (ram_rd),
    .wr_en (ram_wr),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_q)
  );

  ecc_word_dec #(.DATA_W(DATA_W)) u_dec (
    .data (ram_q[DATA_W-1:0]),
    .chk  (ram_q[WORD_W-1:DATA_W]),
    .corr (corr_data),
    .sec  (dec_sec),
    .ded  (dec_ded)
  );

  assign rsp_valid = busy;
  assign rsp_rdata = corr_data;
  assign rsp_sec   = busy & dec_sec;
  assign rsp_ded   = busy & dec_ded;

endmodule

// File: rtl/ecc_word_ram_chk.sv
module ecc_word_ram_chk #(
  parameter int BYTES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic [BYTES-1:0] req_be,
  input logic             rsp_valid,
  input logic             rsp_sec,
  input logic             rsp_ded
);

  // R3 R6
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !(req_write && (&req_be))) |=> (rsp_valid && !req_ready));

  // R4
  full_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && (&req_be)) |=> (!rsp_valid && req_ready));

  // R3
  single_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (req_ready && !rsp_valid));

  // R12
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_sec && rsp_ded));

endmodule

bind ecc_word_ram ecc_word_ram_chk #(.BYTES(BYTES)) u_chk (.*);

// File: tb/test_ecc_word_ram.sv
module test_ecc_word_ram;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;
  localparam int AW = 4;
  localparam int HW = 7;

  logic          clk, rst_n;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [7:0]    req_be;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid, rsp_sec, rsp_ded;
  logic [DW-1:0] rsp_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [DW-1:0] model [16];

  ecc_word_ram #(.DATA_W(DW), .ADDR_W(AW)) i_ecc_word_ram (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // expected check bits following R1
  function automatic logic [7:0] enc(input logic [DW-1:0] d);
    logic [HW-1:0] h;
    int pos, j;
    h = '0; j = 0;
    for (pos = 1; j < DW; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        for (int i = 0; i < HW; i++)
          if (((pos >> i) & 1) == 1) h[i] ^= d[j];
        j++;
      end
    end
    return {^{d, h}, h};
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                          input logic [7:0] be);
    logic [DW-1:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = be[b] ? n[8*b +: 8] : o[8*b +: 8];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic req(input bit wr, input logic [AW-1:0] a, input logic [7:0] be,
                     input logic [DW-1:0] d, output bit v, output bit rdy,
                     output logic [DW-1:0] q, output bit s, output bit e);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
    @(posedge clk);
    #1;
    req_valid = 1'b0; req_write = 1'b0;
    @(negedge clk);
    v = rsp_valid; rdy = req_ready; q = rsp_rdata; s = rsp_sec; e = rsp_ded;
  endtask

  task automatic plant(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [71:0] flip);
    @(negedge clk);
    i_ecc_word_ram.u_ram.mem[a] = {enc(d), d} ^ flip;
  endtask

  task automatic rd_expect(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input bit s_exp, input bit e_exp);
    bit v, rdy, s, e;
    logic [DW-1:0] q;
    req(1'b0, a, 8'h00, '0, v, rdy, q, s, e);
    check(v && !rdy, {tag, " handshake"}, {62'd0, v, rdy}, 64'd2);
    check(q === d, {tag, " data"}, q, d);
    check(s == s_exp && e == e_exp, {tag, " flags"}, {62'd0, s, e}, {62'd0, s_exp, e_exp});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit v, rdy, s, e;
    logic [DW-1:0] q, d, d2;
    logic [7:0] be;
    logic [AW-1:0] a;
    int seed_val;
    seed_val = $urandom(32'd77);
    req_valid = 0; req_write = 0; req_addr = '0; req_be = '0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req_ready && !rsp_valid, "R4 reset state", {62'd0, req_ready, rsp_valid}, 64'd2);

    // R4 full-word writes fill the array
    for (int i = 0; i < 16; i++) begin
      d = {$urandom, $urandom};
      model[i] = d;
      req(1'b1, AW'(i), 8'hFF, d, v, rdy, q, s, e);
      check(!v && rdy, "R4 full write quiet", {62'd0, v, rdy}, 64'd1);
    end

    // R2 R3 plain reads
    rd_expect("R2 R3 read a3", 4'd3, model[3], 0, 0);
    rd_expect("R2 read a15", 4'd15, model[15], 0, 0);

    // R5 R6 partial writes
    d = {$urandom, $urandom};
    req(1'b1, 4'd5, 8'h0F, d, v, rdy, q, s, e);
    check(v && !rdy && !s && !e, "R6 partial rsp", {60'd0, v, rdy, s, e}, 64'h8);
    check(q === model[5], "R6 old word", q, model[5]);
    model[5] = merge(model[5], d, 8'h0F);
    rd_expect("R5 merge low", 4'd5, model[5], 0, 0);
    req(1'b1, 4'd5, 8'h81, ~d, v, rdy, q, s, e);
    model[5] = merge(model[5], ~d, 8'h81);
    rd_expect("R5 merge edges", 4'd5, model[5], 0, 0);

    // R1 deposit a bench-encoded entry
    d = 64'hDEAD_BEEF_0123_4567;
    plant(4'd7, d, '0); model[7] = d;
    rd_expect("R1 layout", 4'd7, d, 0, 0);

    // R7 single data bit errors at both ends
    plant(4'd8, d, 72'd1);
    rd_expect("R7 bit0", 4'd8, d, 1, 0);
    plant(4'd8, d, 72'd1 << 63);
    rd_expect("R7 bit63", 4'd8, d, 1, 0);

    // R11 check bit errors
    plant(4'd8, d, 72'd1 << 71);
    rd_expect("R11 overall bit", 4'd8, d, 1, 0);
    plant(4'd8, d, 72'd1 << (DW + 3));
    rd_expect("R11 ham bit3", 4'd8, d, 1, 0);

    // R8 double error
    plant(4'd8, d, (72'd1 << 5) | (72'd1 << 40));
    d2 = d ^ ((64'd1 << 5) | (64'd1 << 40));
    rd_expect("R8 double", 4'd8, d2, 0, 1);
    plant(4'd8, d, '0); model[8] = d;

    // R9 partial write onto single-error entry
    d = 64'h0F0F_1234_5678_9ABC;
    plant(4'd9, d, 72'd1 << 20);
    d2 = {$urandom, $urandom};
    req(1'b1, 4'd9, 8'hF0, d2, v, rdy, q, s, e);
    check(v && s && !e, "R9 sec flagged", {61'd0, v, s, e}, 64'h6);
    model[9] = merge(d, d2, 8'hF0);
    rd_expect("R9 rewritten clean", 4'd9, model[9], 0, 0);

    // R10 partial write onto double-error entry
    plant(4'd10, d, (72'd1 << 2) | (72'd1 << 50));
    d2 = d ^ ((64'd1 << 2) | (64'd1 << 50));
    req(1'b1, 4'd10, 8'h3C, 64'hFFFF_FFFF_FFFF_FFFF, v, rdy, q, s, e);
    check(v && !s && e, "R10 ded flagged", {61'd0, v, s, e}, 64'h5);
    rd_expect("R10 memory kept", 4'd10, d2, 0, 1);
    plant(4'd10, d, '0); model[10] = d;

    // random mix
    for (int n = 0; n < 400; n++) begin
      a = AW'($urandom % 16);
      d = {$urandom, $urandom};
      case ($urandom % 3)
        0: rd_expect("R2 random read", a, model[a], 0, 0);
        1: begin
          req(1'b1, a, 8'hFF, d, v, rdy, q, s, e);
          check(!v && rdy, "R4 random full", {62'd0, v, rdy}, 64'd1);
          model[a] = d;
        end
        default: begin
          be = 8'($urandom);
          if (be == 8'hFF) be = 8'h7F;
          req(1'b1, a, be, d, v, rdy, q, s, e);
          check(v && !rdy && q === model[a] && !s && !e, "R6 random partial", q, model[a]);
          model[a] = merge(model[a], d, be);
        end
      endcase
    end
    for (int i = 0; i < 16; i++) rd_expect("R5 final sweep", AW'(i), model[i], 0, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule